// File: doc/BRIEF.md
# Program Counter with Circular Return Stack

This block holds the program counter of a small 8-bit microcontroller core and produces the instruction fetch address every cycle. The decoder ahead of it raises one of a few strobes: advance, write of the low counter byte from the ALU, absolute jump, call, return (any form of return), and interrupt entry. The block then picks the next counter value. The bits above the low byte come from an external upper-address latch register through two paths. A low-byte write takes all five latch bits. A jump or call takes only the top two latch bits, placed above an 11-bit opcode field.

Calls and interrupt entries push a return address onto an eight-entry return stack. Returns pop it. The stack is a ring: a push past the eighth entry overwrites the oldest one, and a pop from an empty stack returns whatever entry the wrapped pointer selects. No overflow or underflow flag exists, and the pointer cannot be seen from outside the block. The counter itself is 13 bits wide, but only the first 1K words of program space exist, so the fetch address is the counter folded into that range.

Top module: `pc_stack_unit`

## Requirements
- R1: While reset is asserted and after it is released, the counter and the fetch address are 0000h, and all eight stack entries hold 0000h.
- R2: An advance strobe alone increments the counter by one modulo 2^13 on the next clock edge, so 1FFFh is followed by 0000h.
- R3: With no strobe asserted, the counter keeps its value.
- R4: A low-byte write alone loads counter bits [7:0] from the ALU result and counter bits [12:8] from latch bits [4:0].
- R5: A jump alone loads counter bits [10:0] from opcode bits [10:0] and counter bits [12:11] from latch bits [4:3].
- R6: A call loads the counter the way a jump does, and pushes the counter value plus one (modulo 2^13) onto the stack.
- R7: An interrupt entry loads the counter with 0004h, and pushes the counter value it held when the interrupt was taken.
- R8: A return pops the most recently pushed entry, which is still present, into the counter. Pops follow last-in, first-out order.
- R9: The stack pointer wraps modulo 8. The ninth push overwrites the entry of the first push, and the tenth overwrites the second. A pop with no entry pushed returns the entry at the pointer minus one modulo 8. No push or pop changes anything except the counter and the stack.
- R10: The fetch address equals counter bits [9:0], with bits [12:10] forced to zero.
- R11: When several strobes are raised together, exactly one of them acts, chosen in this order from highest to lowest: interrupt, return, call, jump, low-byte write, advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Asynchronous reset, active high |
| adv_i | input | 1 | Advance the counter by one |
| low_wr_i | input | 1 | Load the low byte from the ALU result |
| jump_i | input | 1 | Absolute jump |
| call_i | input | 1 | Call: jump and push the return address |
| pop_i | input | 1 | Return: pop the stack into the counter |
| irq_i | input | 1 | Interrupt entry: vector and push |
| op_i | input | 11 | Target field of the opcode |
| alu_i | input | 8 | ALU result for low-byte writes |
| latch_i | input | 5 | Upper-address latch register |
| pc_o | output | 13 | Full program counter |
| fetch_o | output | 13 | Fetch address folded into the 1K space |

## Verification
Each strobe acts on the first rising edge after it is driven. The counter and the fetch address show the new value on that same edge, since there is one register stage and no pipeline. A pushed return address shows up only later, on the edge of the pop that takes it back. The bench drives inputs on the falling edge and samples a quarter period after the following rising edge. It compares both outputs against an arithmetic model of the counter and the stack, which it advances once per step. The sweeps cover every opcode field value, every latch and ALU pair, all 64 strobe combinations, and stacks that are pushed and popped past their depth.

// File: rtl/pc_stack_pkg.sv
package pc_stack_pkg;

   // Selected source of the next counter value.
   typedef enum logic [2:0] {
      SEL_HOLD = 3'd0,
      SEL_ADV  = 3'd1,
      SEL_LOW  = 3'd2,
      SEL_JUMP = 3'd3,
      SEL_CALL = 3'd4,
      SEL_POP  = 3'd5,
      SEL_IRQ  = 3'd6
   } pc_sel_e;

endpackage

// File: rtl/pc_stack_prio.sv
module pc_stack_prio (
   input  logic                  adv_i,
   input  logic                  low_wr_i,
   input  logic                  jump_i,
   input  logic                  call_i,
   input  logic                  pop_i,
   input  logic                  irq_i,
   output pc_stack_pkg::pc_sel_e sel_o,
   output logic                  push_o,
   output logic                  pop_o
);
   import pc_stack_pkg::*;

   // Fixed priority: interrupt, return, call, jump, low write, advance.
   always_comb begin
      if (irq_i)         sel_o = SEL_IRQ;
      else if (pop_i)    sel_o = SEL_POP;
      else if (call_i)   sel_o = SEL_CALL;
      else if (jump_i)   sel_o = SEL_JUMP;
      else if (low_wr_i) sel_o = SEL_LOW;
      else if (adv_i)    sel_o = SEL_ADV;
      else               sel_o = SEL_HOLD;
   end

   assign push_o = (sel_o == SEL_IRQ) || (sel_o == SEL_CALL);
   assign pop_o  = (sel_o == SEL_POP);

endmodule

// File: rtl/pc_stack_next.sv
module pc_stack_next #(
   parameter int unsigned PC_W    = 13,
   parameter int unsigned LOW_W   = 8,
   parameter int unsigned JMP_W   = 11,
   parameter int unsigned IRQ_VEC = 4
) (
   input  pc_stack_pkg::pc_sel_e  sel_i,
   input  logic [PC_W-1:0]        pc_i,
   input  logic [PC_W-1:0]        pop_data_i,
   input  logic [JMP_W-1:0]       op_i,
   input  logic [LOW_W-1:0]       alu_i,
   input  logic [PC_W-LOW_W-1:0]  latch_i,
   output logic [PC_W-1:0]        next_o,
   output logic [PC_W-1:0]        push_data_o
);
   import pc_stack_pkg::*;

   localparam int unsigned LATCH_W = PC_W - LOW_W;
   localparam int unsigned PAGE_W  = PC_W - JMP_W;

   logic [PC_W-1:0] inc_w;
   logic [PC_W-1:0] jump_w;
   logic [PC_W-1:0] low_w;

   assign inc_w  = pc_i + PC_W'(1);
   assign jump_w = {latch_i[LATCH_W-1 -: PAGE_W], op_i};
   assign low_w  = {latch_i, alu_i};

   always_comb begin
      unique case (sel_i)
         SEL_IRQ:  next_o = PC_W'(IRQ_VEC);
         SEL_POP:  next_o = pop_data_i;
         SEL_CALL: next_o = jump_w;
         SEL_JUMP: next_o = jump_w;
         SEL_LOW:  next_o = low_w;
         SEL_ADV:  next_o = inc_w;
         default:  next_o = pc_i;
      endcase
   end

   // A call resumes after itself; an interrupt resumes the fetch it displaced.
   assign push_data_o = (sel_i == SEL_CALL) ? inc_w : pc_i;

endmodule

// File: rtl/pc_stack_ring.sv
module pc_stack_ring #(
   parameter int unsigned PC_W         = 13,
   parameter int unsigned DEPTH        = 8,
   parameter bit          CLEAR_ON_RST = 1'b1
) (
   input  logic            clk_i,
   input  logic            rst_i,
   input  logic            push_i,
   input  logic            pop_i,
   input  logic [PC_W-1:0] push_data_i,
   output logic [PC_W-1:0] pop_data_o
);
   localparam int unsigned SP_W = $clog2(DEPTH);

   logic [PC_W-1:0] mem_q [DEPTH];
   logic [SP_W-1:0] sp_q;
   logic [SP_W-1:0] top_w;

   // DEPTH is a power of two, so plain modular arithmetic gives the ring.
   assign top_w      = sp_q - SP_W'(1);
   assign pop_data_o = mem_q[top_w];

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i)       sp_q <= '0;
      else if (push_i) sp_q <= sp_q + SP_W'(1);
      else if (pop_i)  sp_q <= top_w;
   end

   generate
      if (CLEAR_ON_RST) begin : g_clear
         always_ff @(posedge clk_i or posedge rst_i) begin
            if (rst_i) begin
               for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
            end else if (push_i) begin
               mem_q[sp_q] <= push_data_i;
            end
         end
      end else begin : g_noclear
         always_ff @(posedge clk_i) begin
            if (push_i) mem_q[sp_q] <= push_data_i;
         end
      end
   endgenerate

endmodule

// File: rtl/pc_stack_unit.sv
module pc_stack_unit #(
   parameter int unsigned PC_W         = 13,
   parameter int unsigned LOW_W        = 8,
   parameter int unsigned JMP_W        = 11,
   parameter int unsigned IMPL_W       = 10,
   parameter int unsigned DEPTH        = 8,
   parameter int unsigned IRQ_VEC      = 4,
   parameter bit          CLEAR_ON_RST = 1'b1
) (
   input  logic                 clk_i,
   input  logic                 rst_i,
   input  logic                 adv_i,
   input  logic                 low_wr_i,
   input  logic                 jump_i,
   input  logic                 call_i,
   input  logic                 pop_i,
   input  logic                 irq_i,
   input  logic [JMP_W-1:0]     op_i,
   input  logic [LOW_W-1:0]     alu_i,
   input  logic [PC_W-LOW_W-1:0] latch_i,
   output logic [PC_W-1:0]      pc_o,
   output logic [PC_W-1:0]      fetch_o
);
   import pc_stack_pkg::*;

   // Elaboration-time parameter checks.
   if (JMP_W >= PC_W || LOW_W >= JMP_W) begin : g_bad_widths
      $error("pc_stack_unit: need LOW_W < JMP_W < PC_W");
   end
   if (IMPL_W == 0 || IMPL_W > PC_W) begin : g_bad_impl
      $error("pc_stack_unit: IMPL_W must be within 1..PC_W");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("pc_stack_unit: DEPTH must be a power of two of at least 2");
   end
   if (IRQ_VEC >= (1 << IMPL_W)) begin : g_bad_vec
      $error("pc_stack_unit: IRQ_VEC must lie in the implemented space");
   end

   pc_sel_e         sel_w;
   logic            push_w;
   logic            pop_w;
   logic [PC_W-1:0] pc_q;
   logic [PC_W-1:0] next_w;
   logic [PC_W-1:0] push_data_w;
   logic [PC_W-1:0] pop_data_w;

   pc_stack_prio u_prio (
      .adv_i    (adv_i),
      .low_wr_i (low_wr_i),
      .jump_i   (jump_i),
      .call_i   (call_i),
      .pop_i    (pop_i),
      .irq_i    (irq_i),
      .sel_o    (sel_w),
      .push_o   (push_w),
      .pop_o    (pop_w)
   );

   pc_stack_next #(
      .PC_W    (PC_W),
      .LOW_W   (LOW_W),
      .JMP_W   (JMP_W),
      .IRQ_VEC (IRQ_VEC)
   ) u_next (
      .sel_i       (sel_w),
      .pc_i        (pc_q),
      .pop_data_i  (pop_data_w),
      .op_i        (op_i),
      .alu_i       (alu_i),
      .latch_i     (latch_i),
      .next_o      (next_w),
      .push_data_o (push_data_w)
   );

   pc_stack_ring #(
      .PC_W         (PC_W),
      .DEPTH        (DEPTH),
      .CLEAR_ON_RST (CLEAR_ON_RST)
   ) u_ring (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .push_i      (push_w),
      .pop_i       (pop_w),
      .push_data_i (push_data_w),
      .pop_data_o  (pop_data_w)
   );

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) pc_q <= '0;
      else       pc_q <= next_w;
   end

   assign pc_o = pc_q;

   generate
      if (IMPL_W < PC_W) begin : g_fold
         assign fetch_o = {{(PC_W-IMPL_W){1'b0}}, pc_q[IMPL_W-1:0]};
      end else begin : g_full
         assign fetch_o = pc_q;
      end
   endgenerate

endmodule

// File: rtl/pc_stack_unit_chk.sv
module pc_stack_unit_chk #(
   parameter int unsigned PC_W    = 13,
   parameter int unsigned LOW_W   = 8,
   parameter int unsigned JMP_W   = 11,
   parameter int unsigned IRQ_VEC = 4
) (
   input logic                   clk_i,
   input logic                   rst_i,
   input logic                   adv_i,
   input logic                   low_wr_i,
   input logic                   jump_i,
   input logic                   call_i,
   input logic                   pop_i,
   input logic                   irq_i,
   input logic [JMP_W-1:0]       op_i,
   input logic [LOW_W-1:0]       alu_i,
   input logic [PC_W-LOW_W-1:0]  latch_i,
   input logic [PC_W-1:0]        pc_o
);
   localparam int unsigned LATCH_W = PC_W - LOW_W;
   localparam int unsigned PAGE_W  = PC_W - JMP_W;

   logic none_w;
   assign none_w = !(adv_i || low_wr_i || jump_i || call_i || pop_i || irq_i);

   AST_IRQ_VECTOR: assert property (@(posedge clk_i) disable iff (rst_i)
      irq_i |=> pc_o == PC_W'(IRQ_VEC)); // R7

   AST_CALL_TARGET: assert property (@(posedge clk_i) disable iff (rst_i)
      (call_i && !irq_i && !pop_i) |=>
         pc_o == {$past(latch_i[LATCH_W-1 -: PAGE_W]), $past(op_i)}); // R6

   AST_JUMP_TARGET: assert property (@(posedge clk_i) disable iff (rst_i)
      (jump_i && !call_i && !irq_i && !pop_i) |=>
         pc_o == {$past(latch_i[LATCH_W-1 -: PAGE_W]), $past(op_i)}); // R5

   AST_LOW_WRITE: assert property (@(posedge clk_i) disable iff (rst_i)
      (low_wr_i && !jump_i && !call_i && !irq_i && !pop_i) |=>
         pc_o == {$past(latch_i), $past(alu_i)}); // R4

   AST_ADVANCE: assert property (@(posedge clk_i) disable iff (rst_i)
      (adv_i && !low_wr_i && !jump_i && !call_i && !irq_i && !pop_i) |=>
         pc_o == $past(pc_o) + PC_W'(1)); // R2

   AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
      none_w |=> $stable(pc_o)); // R3

endmodule

bind pc_stack_unit pc_stack_unit_chk #(
   .PC_W    (PC_W),
   .LOW_W   (LOW_W),
   .JMP_W   (JMP_W),
   .IRQ_VEC (IRQ_VEC)
) u_chk (
   .clk_i    (clk_i),
   .rst_i    (rst_i),
   .adv_i    (adv_i),
   .low_wr_i (low_wr_i),
   .jump_i   (jump_i),
   .call_i   (call_i),
   .pop_i    (pop_i),
   .irq_i    (irq_i),
   .op_i     (op_i),
   .alu_i    (alu_i),
   .latch_i  (latch_i),
   .pc_o     (pc_o)
);

// File: tb/pc_stack_unit_tb_top.sv
module pc_stack_unit_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk_i = 1'b0;
   logic        rst_i = 1'b1;
   logic        adv_i = 0, low_wr_i = 0, jump_i = 0, call_i = 0, pop_i = 0, irq_i = 0;
   logic [10:0] op_i = '0;
   logic [7:0]  alu_i = '0;
   logic [4:0]  latch_i = '0;
   logic [12:0] pc_o, fetch_o;

   int total = 0;
   int bad   = 0;
   int cycles = 0;
   bit done  = 0;

   // Arithmetic model of counter and ring.
   logic [12:0] m_pc;
   logic [12:0] m_stk [8];
   logic [2:0]  m_sp;

   pc_stack_unit dut_i (
      .clk_i (clk_i), .rst_i (rst_i),
      .adv_i (adv_i), .low_wr_i (low_wr_i), .jump_i (jump_i),
      .call_i (call_i), .pop_i (pop_i), .irq_i (irq_i),
      .op_i (op_i), .alu_i (alu_i), .latch_i (latch_i),
      .pc_o (pc_o), .fetch_o (fetch_o)
   );

   always #(CLK_PERIOD/2) clk_i = ~clk_i;

   always @(posedge clk_i) begin
      cycles++;
      if (cycles > WATCHDOG && !done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic m_push(input logic [12:0] v);
      m_stk[m_sp] = v;
      m_sp = m_sp + 3'd1;
   endtask

   // One instruction step: drive at negedge, compare after the next posedge.
   task automatic step(input logic [5:0] s, input logic [10:0] op,
                       input logic [7:0] alu, input logic [4:0] lat, input string tag);
      @(negedge clk_i);
      {irq_i, pop_i, call_i, jump_i, low_wr_i, adv_i} = s;
      op_i = op; alu_i = alu; latch_i = lat;
      if (s[5]) begin
         m_push(m_pc); m_pc = 13'h0004;
      end else if (s[4]) begin
         m_sp = m_sp - 3'd1; m_pc = m_stk[m_sp];
      end else if (s[3]) begin
         m_push(m_pc + 13'd1); m_pc = {lat[4:3], op};
      end else if (s[2]) begin
         m_pc = {lat[4:3], op};
      end else if (s[1]) begin
         m_pc = {lat, alu};
      end else if (s[0]) begin
         m_pc = m_pc + 13'd1;
      end
      @(posedge clk_i);
      #(CLK_PERIOD/4);
      check(tag, pc_o, m_pc);
      check({tag, " R10 fetch"}, fetch_o, {3'b000, m_pc[9:0]});
   endtask

   localparam logic [5:0] S_NONE = 6'b000000, S_ADV = 6'b000001, S_LOW = 6'b000010,
                          S_JMP = 6'b000100, S_CALL = 6'b001000, S_POP = 6'b010000,
                          S_IRQ = 6'b100000;

   initial begin
      m_pc = '0; m_sp = '0;
      for (int k = 0; k < 8; k++) m_stk[k] = '0;
      repeat (3) @(negedge clk_i);
      check("R1 pc in reset", pc_o, 13'h0000);
      check("R1 fetch in reset", fetch_o, 13'h0000);
      rst_i = 1'b0;
      @(negedge clk_i);
      check("R1 pc after reset", pc_o, 13'h0000);

      // R1: empty-stack pop after reset returns a cleared entry.
      step(S_POP, '0, '0, '0, "R1 cleared stack");
      step(S_POP, '0, '0, '0, "R9 underflow pop");

      // R2 / R10: advance across the 1K fold.
      step(S_LOW, '0, 8'h00, 5'h00, "R4 set base");
      for (int i = 0; i < 1100; i++) step(S_ADV, '0, '0, '0, "R2 advance");
      step(S_LOW, '0, 8'hFF, 5'h1F, "R4 top address");
      step(S_ADV, '0, '0, '0, "R2 wrap 1FFF");

      // R3: idle holds.
      step(S_LOW, '0, 8'h5A, 5'h0B, "R4 set");
      for (int i = 0; i < 5; i++) step(S_NONE, 11'h7FF, 8'hFF, 5'h1F, "R3 hold");

      // R4: every latch and ALU pair.
      for (int l = 0; l < 32; l++)
         for (int a = 0; a < 256; a++)
            step(S_LOW, 11'(a * 5), 8'(a), 5'(l), "R4 low write");

      // R5: every opcode field with rotating latch.
      for (int o = 0; o < 2048; o++)
         step(S_JMP, 11'(o), 8'(o), 5'((o * 7) % 32), "R5 jump");

      // R6 / R8: nested calls then returns.
      for (int d = 0; d < 8; d++)
         step(S_CALL, 11'(100 * d + 3), '0, 5'(d * 4), "R6 call");
      for (int d = 0; d < 8; d++) step(S_POP, '0, '0, '0, "R8 return");

      // R7: interrupt from an arbitrary address, then return to it.
      step(S_LOW, '0, 8'h37, 5'h12, "R4 set");
      step(S_IRQ, 11'h123, 8'h44, 5'h1F, "R7 vector");
      step(S_ADV, '0, '0, '0, "R2 in handler");
      step(S_POP, '0, '0, '0, "R7 resume");

      // R9: ring overwrite with ten pushes, then pops past empty.
      for (int d = 0; d < 10; d++)
         step(S_CALL, 11'(d * 37 + 11), '0, 5'(d * 3), "R9 push");
      for (int d = 0; d < 12; d++) step(S_POP, '0, '0, '0, "R9 ring pop");

      // R11: all strobe combinations.
      for (int c = 0; c < 64; c++) begin
         step(S_LOW, '0, 8'(c * 3), 5'(c % 32), "R4 set");
         step(6'(c), 11'(c * 29 + 5), 8'(c * 11), 5'((c + 9) % 32), "R11 priority");
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule